// File: doc/BRIEF.md
# LCD Common Scan and Refresh Sequencer

This block drives the row scan of a dot-matrix LCD driver that keeps its picture in an on-chip display memory of 32 lines by 80 columns. A divided clock tick advances a common counter. For every common the block computes which memory line belongs to it, fetches that line through a read port, and moves the fetched bits into a 61-bit segment latch at the common boundary. While one common is shown, the line for the next common is already being fetched.

The line shown on common n is the programmable start line plus n, wrapped over 32 lines, so rewriting the start line scrolls the picture. Control levels choose a 16-common or 32-common scan, mirrored column order on the segments, a blanked display, and an all-lit static mode. When the display is both blanked and static, the block stops scanning to save power. Two instances can be cascaded. The master owns the frame alternation signal and drives commons 0 to 15. The slave follows that signal and drives commons 16 to 31.

Memory reads use a valid/ready request channel. The block raises `rd_req_valid` with `rd_line` and holds both steady until `rd_req_ready` is seen high on a clock edge. The memory answers with `rd_rsp_valid` for one cycle at some later edge. The response channel has no back-pressure. While the memory withholds ready, the scan cannot advance: a common boundary whose line has not arrived is skipped, and the current common stays on.

Top module: `lcd_scan_seq`

## Requirements
- R1: After reset the start line is 0, the common counter is 0, `fr_out` is low, and `com_sel` and `seg_out` stay all zero until the first common boundary. The first lines shown then come from start line 0.
- R2: One common boundary occurs every DIV clocks. With `duty32`=0 the counter steps 0..15 and wraps. With `duty32`=1 it steps 0..31 and wraps. A master drives `com_sel` bit j one-hot while common j (j<16) is current, so with `duty32`=1 the gap from common 15 to common 0 is 17 boundaries.
- R3: Common n shows memory line (start + n) mod 32. In `rd_rsp_data`, bit c is column c of the requested line.
- R4: With `seg_rev`=0, `seg_out[k]` is column k. With `seg_rev`=1, `seg_out[k]` is column 79-k.
- R5: A cycle with `start_wr` high loads `start_val` into the start line register. Line fetches issued after the write use the new value.
- R6: `disp_off`=1 forces `com_sel` and `seg_out` to zero whatever the memory holds. Scanning and fetching continue.
- R7: `static_on`=1 with `disp_off`=0 drives every `com_sel` and `seg_out` bit to 1.
- R8: `disp_off`=1 together with `static_on`=1 is power save: no new line request is issued, the common counter and `fr_out` hold, and scanning resumes when either flag drops.
- R9: On a master, `fr_out` toggles at the boundary where the counter wraps from the last common of the selected duty back to 0.
- R10: With `is_master`=0, `fr_out` follows `fr_in`, and `com_sel` bit j marks common j+16 (never active with `duty32`=0). A change on `fr_in` that finds the slave away from common 0 realigns its counter and tick phase, so its common 16 starts on the same clock edge as the master's.
- R11: Once raised, `rd_req_valid` and `rd_line` stay unchanged until `rd_req_ready` is high. A boundary whose line has not yet arrived is skipped, and `com_sel` and `seg_out` hold.
- R12: The segment latch changes only at common boundaries. The line for the next common is fetched during the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1: master role, 0: slave role |
| start_wr | input | 1 | Start line write strobe |
| start_val | input | 5 | Start line value, 0 to 31 |
| duty32 | input | 1 | 0: 16 commons, 1: 32 commons |
| seg_rev | input | 1 | 1: mirrored column order on segments |
| disp_off | input | 1 | Blank all outputs |
| static_on | input | 1 | Static all-lit drive |
| fr_in | input | 1 | Frame alternation from the master (slave role) |
| rd_req_valid | output | 1 | Line read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_line | output | 5 | Requested memory line |
| rd_rsp_valid | input | 1 | Line data valid, one cycle |
| rd_rsp_data | input | 80 | Line data, bit c is column c |
| com_sel | output | 16 | One-hot common select |
| seg_out | output | 61 | Segment latch output |
| fr_out | output | 1 | Frame alternation signal |

## Verification
The bench builds a master and a slave with DIV set to 8 and the default geometry of 16 commons per chip, 32 lines, 80 columns and 61 segments. The short divider makes a 32-common frame last 256 clocks. That leaves room for many frames under each start line, duty and mirroring setting, and for the slave to drift out of step after the master's memory stalls and then realign. With DIV at 8, a realignment leaves six clocks for the refetch, which exercises the tightest fetch window.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // line fetch engine states
  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_REQ  = 2'd1,
    FE_WAIT = 2'd2,
    FE_FULL = 2'd3
  } fetch_st_e;

  // wrap a start line plus common offset over the memory height
  function automatic int unsigned wrap_line(input int unsigned base,
                                            input int unsigned ofs,
                                            input int unsigned height);
    int unsigned s;
    s = base + ofs;
    return (s >= height) ? s - height : s;
  endfunction

endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      // realign: the caller sees the phase reference one clock late
      cnt <= CW'(1);
    end else if (en) begin
      cnt <= (cnt == TOP) ? '0 : cnt + CW'(1);
    end
  end

  assign tick = en && !load && (cnt == TOP);

endmodule

// File: rtl/lcd_line_fetch.sv
module lcd_line_fetch
  import lcd_scan_pkg::*;
#(
  parameter int LW    = 5,
  parameter int COL_N = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want,
  input  logic [LW-1:0]    line_in,
  input  logic             consume,
  input  logic             flush,
  output logic             buf_full,
  output logic [COL_N-1:0] buf_data,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [LW-1:0]    req_line,
  input  logic             rsp_valid,
  input  logic [COL_N-1:0] rsp_data
);
  fetch_st_e st;
  logic      drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= FE_IDLE;
      drop     <= 1'b0;
      req_line <= '0;
      buf_data <= '0;
    end else begin
      unique case (st)
        FE_IDLE: begin
          if (want && !flush) begin
            req_line <= line_in;
            st       <= FE_REQ;
          end
        end
        FE_REQ: begin
          if (flush) drop <= 1'b1;
          if (req_ready) st <= FE_WAIT;
        end
        FE_WAIT: begin
          if (rsp_valid) begin
            if (drop || flush) begin
              st <= FE_IDLE;
            end else begin
              buf_data <= rsp_data;
              st       <= FE_FULL;
            end
            drop <= 1'b0;
          end else if (flush) begin
            drop <= 1'b1;
          end
        end
        FE_FULL: begin
          if (consume || flush) st <= FE_IDLE;
        end
        default: st <= FE_IDLE;
      endcase
    end
  end

  assign req_valid = (st == FE_REQ);
  assign buf_full  = (st == FE_FULL);

endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map #(
  parameter int COL_N = 80,
  parameter int SEG_N = 61
) (
  input  logic             rev,
  input  logic [COL_N-1:0] cols,
  output logic [SEG_N-1:0] segs
);
  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    assign segs[k] = rev ? cols[COL_N-1-k] : cols[k];
  end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int COM_OUT = 16,
  parameter int LINE_N  = 32,
  parameter int COL_N   = 80,
  parameter int SEG_N   = 61,
  parameter int DIV     = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_master,
  input  logic               start_wr,
  input  logic [$clog2(LINE_N)-1:0] start_val,
  input  logic               duty32,
  input  logic               seg_rev,
  input  logic               disp_off,
  input  logic               static_on,
  input  logic               fr_in,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [$clog2(LINE_N)-1:0] rd_line,
  input  logic               rd_rsp_valid,
  input  logic [COL_N-1:0]   rd_rsp_data,
  output logic [COM_OUT-1:0] com_sel,
  output logic [SEG_N-1:0]   seg_out,
  output logic               fr_out
);
  localparam int LW = $clog2(LINE_N);
  localparam int IW = $clog2(2 * COM_OUT);
  localparam logic [IW-1:0] LAST_SHORT = IW'(COM_OUT - 1);
  localparam logic [IW-1:0] LAST_LONG  = IW'(2 * COM_OUT - 1);

  logic [LW-1:0]    start_q;
  logic [IW-1:0]    com_cnt;
  logic             active;
  logic [SEG_N-1:0] seg_q;
  logic             fr_q;
  logic             fr_in_q;

  logic [IW-1:0]    last_idx;
  logic [IW-1:0]    nxt_idx;
  logic [LW:0]      line_sum;
  logic [LW-1:0]    line_next;
  logic             pwrsave;
  logic             run;
  logic             fr_edge;
  logic             resync;
  logic             tick;
  logic             consume;
  logic             buf_full;
  logic [COL_N-1:0] buf_data;
  logic [SEG_N-1:0] seg_mapped;
  logic [COM_OUT-1:0] com_vis;

  // start line register
  always_ff @(posedge clk) begin
    if (!rst_n)        start_q <= '0;
    else if (start_wr) start_q <= start_val;
  end

  // next common and its memory line
  always_comb begin
    last_idx  = duty32 ? LAST_LONG : LAST_SHORT;
    nxt_idx   = (!active || com_cnt >= last_idx) ? '0 : com_cnt + IW'(1);
    line_sum  = {1'b0, start_q} + (LW+1)'(nxt_idx);
    line_next = (line_sum >= (LW+1)'(LINE_N)) ? LW'(line_sum - (LW+1)'(LINE_N))
                                               : LW'(line_sum);
  end

  assign pwrsave = disp_off && static_on;
  assign run     = !pwrsave;

  // slave phase tracking of the frame alternation input
  always_ff @(posedge clk) begin
    if (!rst_n) fr_in_q <= 1'b0;
    else        fr_in_q <= fr_in;
  end

  assign fr_edge = !is_master && (fr_in != fr_in_q);
  assign resync  = fr_edge && !(active && (com_cnt == '0));

  lcd_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run),
    .load (resync),
    .tick (tick)
  );

  lcd_line_fetch #(.LW(LW), .COL_N(COL_N)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .want     (run),
    .line_in  (line_next),
    .consume  (consume),
    .flush    (resync),
    .buf_full (buf_full),
    .buf_data (buf_data),
    .req_valid(rd_req_valid),
    .req_ready(rd_req_ready),
    .req_line (rd_line),
    .rsp_valid(rd_rsp_valid),
    .rsp_data (rd_rsp_data)
  );

  lcd_seg_map #(.COL_N(COL_N), .SEG_N(SEG_N)) u_map (
    .rev (seg_rev),
    .cols(buf_data),
    .segs(seg_mapped)
  );

  assign consume = tick && buf_full;

  // common counter, segment latch, frame alternation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      com_cnt <= '0;
      active  <= 1'b0;
      seg_q   <= '0;
      fr_q    <= 1'b0;
    end else if (resync) begin
      com_cnt <= '0;
      active  <= 1'b1;
    end else if (consume) begin
      seg_q   <= seg_mapped;
      com_cnt <= nxt_idx;
      active  <= 1'b1;
      if (is_master && active && (nxt_idx == '0)) fr_q <= !fr_q;
    end
  end

  // one-hot select of the commons this chip owns
  for (genvar j = 0; j < COM_OUT; j++) begin : g_com
    assign com_vis[j] = active &&
                        (is_master ? (com_cnt == IW'(j)) : (com_cnt == IW'(j + COM_OUT)));
  end

  always_comb begin
    if (disp_off) begin
      com_sel = '0;
      seg_out = '0;
    end else if (static_on) begin
      com_sel = '1;
      seg_out = '1;
    end else begin
      com_sel = com_vis;
      seg_out = seg_q;
    end
  end

  assign fr_out = is_master ? fr_q : fr_in;

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int COM_OUT = 16,
  parameter int SEG_N   = 61,
  parameter int LW      = 5,
  parameter int IW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               is_master,
  input logic               disp_off,
  input logic               static_on,
  input logic [COM_OUT-1:0] com_sel,
  input logic               rd_req_valid,
  input logic               rd_req_ready,
  input logic [LW-1:0]      rd_line,
  input logic [IW-1:0]      com_cnt,
  input logic               active,
  input logic [SEG_N-1:0]   seg_q,
  input logic               fr_q,
  input logic               tick,
  input logic               buf_full
);

  p_com_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !static_on |-> $onehot0(com_sel));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_line)));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !buf_full) |=> ($stable(com_cnt) && $stable(seg_q)));

  p_latch_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_q) |-> (!$stable(com_cnt) || $rose(active)));

  p_fr_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !$stable(fr_q)) |-> (com_cnt == '0));

  p_pwrsave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && disp_off && static_on) |=> ($stable(fr_q) && $stable(com_cnt)));

endmodule

bind lcd_scan_seq lcd_scan_chk #(
  .COM_OUT(COM_OUT),
  .SEG_N  (SEG_N),
  .LW     (LW),
  .IW     (IW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .is_master   (is_master),
  .disp_off    (disp_off),
  .static_on   (static_on),
  .com_sel     (com_sel),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_line     (rd_line),
  .com_cnt     (com_cnt),
  .active      (active),
  .seg_q       (seg_q),
  .fr_q        (fr_q),
  .tick        (tick),
  .buf_full    (buf_full)
);

// File: tb/lcd_scan_seq_tb_top.sv
module lcd_scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_DIV     = 8;
  localparam int NCOL       = 80;
  localparam int NSEG       = 61;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start_wr = 1'b0;
  logic [4:0] start_val = '0;
  logic       duty32 = 1'b0, seg_rev = 1'b0, disp_off = 1'b0, static_on = 1'b0;
  logic       ram_stall = 1'b0;

  // master side
  logic            m_req_v, m_rsp_v = 1'b0, m_fr;
  logic [4:0]      m_line;
  logic [NCOL-1:0] m_rsp_d = '0;
  logic [15:0]     m_com;
  logic [NSEG-1:0] m_seg;
  // slave side
  logic            s_req_v, s_rsp_v = 1'b0, s_fr;
  logic [4:0]      s_line;
  logic [NCOL-1:0] s_rsp_d = '0;
  logic [15:0]     s_com;
  logic [NSEG-1:0] s_seg;

  lcd_scan_seq #(.DIV(TB_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .is_master(1'b1), .start_wr(start_wr), .start_val(start_val),
    .duty32(duty32), .seg_rev(seg_rev), .disp_off(disp_off), .static_on(static_on),
    .fr_in(1'b0), .rd_req_valid(m_req_v), .rd_req_ready(!ram_stall), .rd_line(m_line),
    .rd_rsp_valid(m_rsp_v), .rd_rsp_data(m_rsp_d), .com_sel(m_com), .seg_out(m_seg),
    .fr_out(m_fr));

  lcd_scan_seq #(.DIV(TB_DIV)) slv_i (
    .clk(clk), .rst_n(rst_n), .is_master(1'b0), .start_wr(start_wr), .start_val(start_val),
    .duty32(duty32), .seg_rev(seg_rev), .disp_off(disp_off), .static_on(static_on),
    .fr_in(m_fr), .rd_req_valid(s_req_v), .rd_req_ready(1'b1), .rd_line(s_line),
    .rd_rsp_valid(s_rsp_v), .rd_rsp_data(s_rsp_d), .com_sel(s_com), .seg_out(s_seg),
    .fr_out(s_fr));

  // memory content: an asymmetric pattern per line
  function automatic logic [NCOL-1:0] ram_row(input int ln);
    logic [NCOL-1:0] r;
    for (int c = 0; c < NCOL; c++) r[c] = (((c * 3 + ln * 5) % 7) < 3);
    return r;
  endfunction

  function automatic logic [NSEG-1:0] exp_seg(input int ln, input bit rev);
    logic [NCOL-1:0] r;
    logic [NSEG-1:0] s;
    r = ram_row(ln);
    for (int k = 0; k < NSEG; k++) s[k] = rev ? r[NCOL-1-k] : r[k];
    return s;
  endfunction

  function automatic int oh_idx(input logic [15:0] v);
    int r;
    r = -1;
    for (int i = 0; i < 16; i++) if (v[i]) r = i;
    return r;
  endfunction

  // memory models, one-cycle response
  int hs_cnt = 0;
  always @(posedge clk) begin
    m_rsp_v <= m_req_v && !ram_stall;
    m_rsp_d <= ram_row(int'(m_line));
    s_rsp_v <= s_req_v;
    s_rsp_d <= ram_row(int'(s_line));
    if (m_req_v && !ram_stall) hs_cnt <= hs_cnt + 1;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor state
  bit   mon_en = 1'b0;
  int   exp_start = 0;
  bit   exp_duty32 = 1'b0, exp_rev = 1'b0;
  int   cyc = 0, m_prev = -1, s_prev = -1, m_last_cyc = 0, m_fr0 = -1;
  logic [15:0]     last_m_com = '0, last_s_com = '0;
  logic [NSEG-1:0] last_m_seg = '0;

  always @(negedge clk) begin
    int  idx, sidx, gap_exp;
    bit  m_chg;
    cyc++;
    m_chg = (m_com != last_m_com);
    if (mon_en) begin
      if (m_chg && m_com != '0) begin
        idx = oh_idx(m_com);
        // R3 R4: content of common idx is line start+idx, mapped by orientation
        chk(m_seg == exp_seg((exp_start + idx) % 32, exp_rev), "R3 R4 master segments",
            64'(m_seg), 64'(exp_seg((exp_start + idx) % 32, exp_rev)));
        if (m_prev >= 0) begin
          chk(idx == (m_prev + 1) % 16, "R2 common order", 64'(idx), 64'((m_prev + 1) % 16));
          gap_exp = (m_prev == 15) ? (exp_duty32 ? 17 : 1) * TB_DIV : TB_DIV;
          chk(cyc - m_last_cyc == gap_exp, "R2 boundary spacing",
              64'(cyc - m_last_cyc), 64'(gap_exp));
        end
        if (idx == 0) begin
          if (m_fr0 >= 0) chk(m_fr != m_fr0[0], "R9 frame toggle", 64'(m_fr), 64'(!m_fr0[0]));
          m_fr0 = int'(m_fr);
        end
        m_prev = idx;
        m_last_cyc = cyc;
      end
      if (!exp_duty32 && m_seg != last_m_seg)
        chk(m_chg, "R12 latch only at boundary", 64'(m_chg), 64'(1));
      if (s_com != last_s_com && s_com != '0) begin
        if (!exp_duty32) begin
          chk(1'b0, "R10 slave idle in 1/16", 64'(s_com), 64'(0));
        end else begin
          sidx = oh_idx(s_com) + 16;
          chk(s_seg == exp_seg((exp_start + sidx) % 32, exp_rev), "R10 R3 slave segments",
              64'(s_seg), 64'(exp_seg((exp_start + sidx) % 32, exp_rev)));
          if (s_prev >= 0)
            chk(sidx == ((s_prev - 15) % 16) + 16, "R10 slave order",
                64'(sidx), 64'(((s_prev - 15) % 16) + 16));
          if (sidx == 16)
            chk(m_chg && m_com == '0, "R10 slave aligned to master", 64'(m_com), 64'(0));
          s_prev = sidx;
        end
      end
    end
    last_m_com = m_com;
    last_s_com = s_com;
    last_m_seg = m_seg;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mon_start(input int st, input bit d, input bit rv);
    exp_start = st; exp_duty32 = d; exp_rev = rv;
    m_prev = -1; s_prev = -1; m_fr0 = -1;
    mon_en = 1'b1;
  endtask

  task automatic run_cfg(input int st, input bit d, input bit rv);
    mon_en = 1'b0;
    @(negedge clk);
    start_val = 5'(st); start_wr = 1'b1; duty32 = d; seg_rev = rv;
    @(negedge clk);
    start_wr = 1'b0;
    wait_clk(40 * TB_DIV);
    mon_start(st, d, rv);
    wait_clk(70 * TB_DIV);
    mon_en = 1'b0;
  endtask

  // stimulus table: {start line, duty32, seg_rev}
  localparam int NVEC = 6;
  localparam logic [6:0] VEC [NVEC] = '{
    {5'd5,  1'b0, 1'b0},
    {5'd31, 1'b0, 1'b1},
    {5'd12, 1'b1, 1'b0},
    {5'd20, 1'b1, 1'b1},
    {5'd3,  1'b1, 1'b1},
    {5'd17, 1'b0, 1'b0}
  };

  initial begin
    int hs0;
    logic fr0;
    logic [4:0]  ln0;
    logic [15:0] com0;
    // R1: reset state
    wait_clk(4);
    chk(m_com == '0, "R1 reset com", 64'(m_com), 64'(0));
    chk(m_seg == '0, "R1 reset seg", 64'(m_seg), 64'(0));
    chk(m_fr == 1'b0, "R1 reset fr", 64'(m_fr), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_com == '0 && m_seg == '0, "R1 blank before first boundary", 64'(m_com), 64'(0));
    // R1: start line cleared, content from line 0 onward
    mon_start(0, 1'b0, 1'b0);
    wait_clk(40 * TB_DIV);
    mon_en = 1'b0;

    // R2 R3 R4 R5 R9 R10 R12 through the table
    for (int v = 0; v < NVEC; v++) run_cfg(int'(VEC[v][6:2]), VEC[v][1], VEC[v][0]);

    // R6: display off blanks, scanning goes on
    duty32 = 1'b0; seg_rev = 1'b0;
    disp_off = 1'b1;
    hs0 = hs_cnt;
    for (int i = 0; i < 6; i++) begin
      wait_clk(TB_DIV);
      chk(m_com == '0 && m_seg == '0, "R6 blanked outputs", 64'(m_seg), 64'(0));
    end
    chk(hs_cnt > hs0, "R6 fetching continues", 64'(hs_cnt), 64'(hs0 + 1));
    disp_off = 1'b0;

    // R7: static all lit
    static_on = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_clk(TB_DIV);
      chk(m_com == 16'hFFFF, "R7 static commons", 64'(m_com), 64'hFFFF);
      chk(m_seg == '1, "R7 static segments", 64'(m_seg), 64'((65'd1 << NSEG) - 1));
    end

    // R8: power save halts scanning
    disp_off = 1'b1;
    wait_clk(3);
    hs0 = hs_cnt;
    fr0 = m_fr;
    wait_clk(40 * TB_DIV);
    chk(hs_cnt == hs0, "R8 no requests in power save", 64'(hs_cnt), 64'(hs0));
    chk(m_fr == fr0, "R8 fr holds in power save", 64'(m_fr), 64'(fr0));
    chk(m_com == '0, "R8 commons off", 64'(m_com), 64'(0));
    disp_off = 1'b0; static_on = 1'b0;
    wait_clk(3 * TB_DIV);
    chk(hs_cnt > hs0, "R8 scanning resumes", 64'(hs_cnt), 64'(hs0 + 1));

    // R11: memory back-pressure
    ram_stall = 1'b1;
    wait_clk(2 * TB_DIV);
    ln0 = m_line;
    com0 = m_com;
    chk(m_req_v == 1'b1, "R11 request pending", 64'(m_req_v), 64'(1));
    wait_clk(4 * TB_DIV);
    chk(m_req_v == 1'b1 && m_line == ln0, "R11 request held stable", 64'(m_line), 64'(ln0));
    chk(m_com == com0, "R11 common holds while stalled", 64'(m_com), 64'(com0));
    ram_stall = 1'b0;
    wait_clk(3 * TB_DIV);
    chk(m_com != com0, "R11 scan resumes after stall", 64'(m_com), 64'(com0));

    // R10: slave realigns after the stall put it out of step
    run_cfg(9, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule